// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block keeps recently used virtual-to-physical page mappings for 4 KB pages in a small fully associative array. A lookup presents a virtual address together with its access kind (load or store) and privilege level. In the same cycle the virtual page number is compared against every valid slot. On a hit the block returns the physical address, which is the stored physical page number joined with the untouched 12-bit page offset, and it flags a protection fault when the slot's permissions do not allow the access. When no slot matches, the block raises a miss so that an external page walker can fetch the mapping.

The walker installs mappings through a refill port. A mapping for a page that is already present is rewritten in its own slot. A mapping for a new page goes to the lowest-numbered empty slot. Only when every slot is occupied does it replace the slot under a round-robin (first-in, first-out) pointer. A flush input empties the whole array in one cycle.

Top module: `tlb_fa`

## Requirements
- R1: After reset every slot is empty, so any lookup reports a miss.
- R2: A lookup whose page number matches a valid slot asserts hit in the same cycle. When the access is permitted, the physical address is the slot's page number in bits 31:12 and the lookup's bits 11:0.
- R3: A lookup that matches no valid slot asserts miss, with hit and fault low and a physical address of zero. While lookup-valid is low, hit, miss and fault are all low.
- R4: A load (store input 0) to a slot whose read permission is clear asserts fault together with hit, and the physical address is zero.
- R5: A store (store input 1) faults unless the slot has both write permission and its dirty bit set. A store to a clean, writable page therefore faults, so that the walker can set the dirty bit by refilling.
- R6: A user-mode access (user input 1) faults on a slot whose user bit is clear. A supervisor access (user input 0) is not restricted by the user bit.
- R7: A refill whose page number equals that of a valid slot rewrites that slot in place. Lookups then return the new page number, no page number is ever held by two valid slots, and the round-robin pointer does not move.
- R8: A refill of a new page while empty slots exist writes the lowest-numbered empty slot and leaves the round-robin pointer unchanged.
- R9: A refill of a new page into a full array replaces the slot at the round-robin pointer, which starts at 0 and then advances by one, wrapping from 63 to 0.
- R10: Flush empties every slot and returns the round-robin pointer to 0 at the next clock edge. A refill in the same cycle is discarded.
- R11: A refill takes effect at the clock edge. A lookup in the refill's own cycle sees the earlier contents, and from the next cycle it sees the new mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_all | input | 1 | Empty all slots and return the round-robin pointer to 0 |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_store | input | 1 | 1 = store access, 0 = load access |
| lk_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| lk_hit | output | 1 | A valid slot matched the page number |
| lk_miss | output | 1 | No valid slot matched; refill needed |
| lk_fault | output | 1 | Matched, but the access is not permitted |
| lk_paddr | output | 32 | Translated address; zero on miss or fault |
| fill_en | input | 1 | Install a mapping at the next edge |
| fill_vpn | input | 20 | Virtual page number of the mapping |
| fill_ppn | input | 20 | Physical page number of the mapping |
| fill_rd | input | 1 | Read permission |
| fill_wr | input | 1 | Write permission |
| fill_dirty | input | 1 | Dirty bit |
| fill_user | input | 1 | Page accessible from user mode |

## Verification
A corrupted permission or dirty bit shows up in the same cycle as a wrong fault on the very first access to that page. A wrong page number shows up at once as a wrong physical address. A faulty round-robin pointer or empty-slot search stays hidden until the array is full, and it appears only when the next new page evicts the wrong slot: a page that should survive starts missing, or one that should be gone still hits. The bench therefore fills the array completely and probes the survivors of each eviction. A slot left valid after a flush appears as a hit on the first lookup of the following cycle.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W     = 32;
    localparam int PA_W     = 32;
    localparam int OFF_W    = 12;
    localparam int VPN_W    = VA_W - OFF_W;
    localparam int PPN_W    = PA_W - OFF_W;

    typedef struct packed {
        logic             valid;
        logic             rd;
        logic             wr;
        logic             dirty;
        logic             user;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
    } tlb_slot_t;

    typedef enum logic [1:0] {
        VIC_MATCH = 2'd0,
        VIC_EMPTY = 2'd1,
        VIC_FIFO  = 2'd2
    } victim_kind_t;

    // True when the access kind and privilege are allowed by the slot.
    function automatic logic access_ok(input tlb_slot_t s, input logic is_store,
                                       input logic user_mode);
        logic kind_ok;
        kind_ok = is_store ? (s.wr && s.dirty) : s.rd;
        return kind_ok && (!user_mode || s.user);
    endfunction
endpackage

// File: rtl/tlb_slot_array.sv
module tlb_slot_array
    import tlb_pkg::*;
#(
    parameter int N_ENTRIES = 64,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear_all,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  tlb_slot_t            wr_slot,
    input  logic [VPN_W-1:0]     look_vpn,
    input  logic [VPN_W-1:0]     fill_vpn,
    output logic [N_ENTRIES-1:0] look_match,
    output logic [N_ENTRIES-1:0] fill_match,
    output logic [N_ENTRIES-1:0] valid_vec,
    output tlb_slot_t            look_slot
);
    tlb_slot_t slots [N_ENTRIES];
    tlb_slot_t masked [N_ENTRIES];

    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || clear_all) begin
                slots[i].valid <= 1'b0;
            end else if (wr_en && wr_idx == IDX_W'(i)) begin
                slots[i] <= wr_slot;
            end
        end

        assign valid_vec[i]  = slots[i].valid;
        assign look_match[i] = slots[i].valid && (slots[i].vpn == look_vpn);
        assign fill_match[i] = slots[i].valid && (slots[i].vpn == fill_vpn);
        assign masked[i]     = look_match[i] ? slots[i] : '0;
    end

    // One-hot OR mux: at most one slot matches a page number.
    always_comb begin
        look_slot = '0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            look_slot = look_slot | masked[i];
        end
    end
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel
    import tlb_pkg::*;
#(
    parameter int N_ENTRIES = 64,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic [N_ENTRIES-1:0] fill_match,
    input  logic [N_ENTRIES-1:0] valid_vec,
    input  logic [IDX_W-1:0]     rr_ptr,
    output logic [IDX_W-1:0]     victim_idx,
    output victim_kind_t         victim_kind
);
    logic [IDX_W-1:0] match_idx;
    logic [IDX_W-1:0] empty_idx;
    logic             any_match;
    logic             any_empty;

    always_comb begin
        match_idx = '0;
        empty_idx = '0;
        any_match = 1'b0;
        any_empty = 1'b0;
        // Descending scan so the lowest index wins.
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (fill_match[i]) begin
                match_idx = IDX_W'(i);
                any_match = 1'b1;
            end
            if (!valid_vec[i]) begin
                empty_idx = IDX_W'(i);
                any_empty = 1'b1;
            end
        end
    end

    always_comb begin
        if (any_match) begin
            victim_idx  = match_idx;
            victim_kind = VIC_MATCH;
        end else if (any_empty) begin
            victim_idx  = empty_idx;
            victim_kind = VIC_EMPTY;
        end else begin
            victim_idx  = rr_ptr;
            victim_kind = VIC_FIFO;
        end
    end
endmodule

// File: rtl/tlb_perm_check.sv
module tlb_perm_check
    import tlb_pkg::*;
(
    input  tlb_slot_t slot,
    input  logic      is_store,
    input  logic      user_mode,
    output logic      deny
);
    assign deny = !access_ok(slot, is_store, user_mode);
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
    import tlb_pkg::*;
#(
    parameter int N_ENTRIES = 64,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush_all,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic             lk_store,
    input  logic             lk_user,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic             lk_fault,
    output logic [PA_W-1:0]  lk_paddr,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_rd,
    input  logic             fill_wr,
    input  logic             fill_dirty,
    input  logic             fill_user
);
    logic [N_ENTRIES-1:0] look_match;
    logic [N_ENTRIES-1:0] fill_match;
    logic [N_ENTRIES-1:0] valid_vec;
    tlb_slot_t            look_slot;
    tlb_slot_t            new_slot;
    logic [IDX_W-1:0]     rr_ptr;
    logic [IDX_W-1:0]     victim_idx;
    victim_kind_t         victim_kind;
    logic                 deny;
    logic                 any_hit;
    logic                 do_fill;

    assign do_fill = fill_en && !flush_all;

    always_comb begin
        new_slot       = '0;
        new_slot.valid = 1'b1;
        new_slot.rd    = fill_rd;
        new_slot.wr    = fill_wr;
        new_slot.dirty = fill_dirty;
        new_slot.user  = fill_user;
        new_slot.vpn   = fill_vpn;
        new_slot.ppn   = fill_ppn;
    end

    tlb_slot_array #(.N_ENTRIES(N_ENTRIES)) u_array (
        .clk        (clk),
        .rst        (rst),
        .clear_all  (flush_all),
        .wr_en      (do_fill),
        .wr_idx     (victim_idx),
        .wr_slot    (new_slot),
        .look_vpn   (lk_vaddr[VA_W-1:OFF_W]),
        .fill_vpn   (fill_vpn),
        .look_match (look_match),
        .fill_match (fill_match),
        .valid_vec  (valid_vec),
        .look_slot  (look_slot)
    );

    tlb_victim_sel #(.N_ENTRIES(N_ENTRIES)) u_victim (
        .fill_match  (fill_match),
        .valid_vec   (valid_vec),
        .rr_ptr      (rr_ptr),
        .victim_idx  (victim_idx),
        .victim_kind (victim_kind)
    );

    tlb_perm_check u_perm (
        .slot      (look_slot),
        .is_store  (lk_store),
        .user_mode (lk_user),
        .deny      (deny)
    );

    always_ff @(posedge clk) begin
        if (rst || flush_all) begin
            rr_ptr <= '0;
        end else if (do_fill && victim_kind == VIC_FIFO) begin
            rr_ptr <= (rr_ptr == IDX_W'(N_ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
        end
    end

    assign any_hit  = |look_match;
    assign lk_hit   = lk_valid && any_hit;
    assign lk_miss  = lk_valid && !any_hit;
    assign lk_fault = lk_hit && deny;
    assign lk_paddr = (lk_hit && !deny) ? {look_slot.ppn, lk_vaddr[OFF_W-1:0]} : '0;
endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk
    import tlb_pkg::*;
#(
    parameter int N_ENTRIES = 64
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 flush_all,
    input logic                 lk_valid,
    input logic [VA_W-1:0]      lk_vaddr,
    input logic                 lk_hit,
    input logic                 lk_miss,
    input logic                 lk_fault,
    input logic [PA_W-1:0]      lk_paddr,
    input logic                 fill_en,
    input logic [VPN_W-1:0]     fill_vpn,
    input logic [N_ENTRIES-1:0] look_match
);
    // R3: hit and miss never together; idle lookup drives nothing
    a_r3_hit_miss_excl: assert property (@(posedge clk) disable iff (rst)
        !(lk_hit && lk_miss));
    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |-> !(lk_hit || lk_miss || lk_fault));
    // R4: a fault is only reported on a hit and blanks the address
    a_r4_fault_blanks: assert property (@(posedge clk) disable iff (rst)
        lk_fault |-> (lk_hit && lk_paddr == '0));
    // R2: page offset passes through untouched on a good hit
    a_r2_offset_pass: assert property (@(posedge clk) disable iff (rst)
        (lk_hit && !lk_fault) |-> lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]);
    // R7: no page number held by two valid slots
    a_r7_single_match: assert property (@(posedge clk) disable iff (rst)
        $onehot0(look_match));
    // R10: the cycle after a flush nothing can hit
    a_r10_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush_all |=> !lk_hit);
    // R11: an accepted refill is visible on the next cycle
    a_r11_fill_visible: assert property (@(posedge clk) disable iff (rst)
        (fill_en && !flush_all) |=>
            ((lk_valid && lk_vaddr[VA_W-1:OFF_W] == $past(fill_vpn)) -> lk_hit));
endmodule

bind tlb_fa tlb_fa_chk #(.N_ENTRIES(N_ENTRIES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .flush_all  (flush_all),
    .lk_valid   (lk_valid),
    .lk_vaddr   (lk_vaddr),
    .lk_hit     (lk_hit),
    .lk_miss    (lk_miss),
    .lk_fault   (lk_fault),
    .lk_paddr   (lk_paddr),
    .fill_en    (fill_en),
    .fill_vpn   (fill_vpn),
    .look_match (look_match)
);

// File: tb/sim_tlb_fa.sv
module sim_tlb_fa;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 64;

    logic        clk = 1'b0;
    logic        rst;
    logic        flush_all;
    logic        lk_valid;
    logic [31:0] lk_vaddr;
    logic        lk_store;
    logic        lk_user;
    logic        lk_hit;
    logic        lk_miss;
    logic        lk_fault;
    logic [31:0] lk_paddr;
    logic        fill_en;
    logic [19:0] fill_vpn;
    logic [19:0] fill_ppn;
    logic        fill_rd;
    logic        fill_wr;
    logic        fill_dirty;
    logic        fill_user;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tlb_fa #(.N_ENTRIES(N)) u0 (
        .clk(clk), .rst(rst), .flush_all(flush_all),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_store(lk_store), .lk_user(lk_user),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_paddr(lk_paddr),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_rd(fill_rd),
        .fill_wr(fill_wr), .fill_dirty(fill_dirty), .fill_user(fill_user)
    );

    typedef struct packed {
        logic [31:0] va;
        logic        st;
        logic        us;
        logic        hit;
        logic        miss;
        logic        flt;
        logic [31:0] pa;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{32'h00010ABC, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h80010ABC, 4'd2},
        '{32'h00010123, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 32'h80010123, 4'd2},
        '{32'h00020FFF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h80020FFF, 4'd2},
        '{32'h00020000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 32'h00000000, 4'd5},
        '{32'h00030444, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 32'h00000000, 4'd5},
        '{32'h00030444, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h80030444, 4'd2},
        '{32'h00040010, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 32'h00000000, 4'd6},
        '{32'h00040010, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 32'h80040010, 4'd6},
        '{32'h00050008, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 32'h00000000, 4'd4},
        '{32'h00050008, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 32'h80050008, 4'd4},
        '{32'h00060000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 32'h00000000, 4'd3},
        '{32'h00000000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h00000000, 4'd3}
    };

    function automatic string req_name(input logic [3:0] r);
        case (r)
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            default: return "R?";
        endcase
    endfunction

    task automatic check(input string req, input logic h, input logic m, input logic f,
                         input logic [31:0] pa);
        n_tests++;
        if (lk_hit !== h || lk_miss !== m || lk_fault !== f || lk_paddr !== pa) begin
            n_fail++;
            $display("FAIL %s va=%h got hit=%b miss=%b fault=%b pa=%h exp hit=%b miss=%b fault=%b pa=%h",
                     req, lk_vaddr, lk_hit, lk_miss, lk_fault, lk_paddr, h, m, f, pa);
        end
    endtask

    // Drive a lookup after the negative edge and sample before the next edge.
    task automatic probe(input logic [31:0] va, input logic st, input logic us);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_vaddr = va;
        lk_store = st;
        lk_user  = us;
        #1;
    endtask

    task automatic expect_hit(input string req, input logic [19:0] vpn, input logic [19:0] ppn);
        probe({vpn, 12'h5A5}, 1'b0, 1'b0);
        check(req, 1'b1, 1'b0, 1'b0, {ppn, 12'h5A5});
    endtask

    task automatic expect_miss(input string req, input logic [19:0] vpn);
        probe({vpn, 12'h001}, 1'b0, 1'b0);
        check(req, 1'b0, 1'b1, 1'b0, 32'h0);
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn, input logic r,
                        input logic w, input logic d, input logic u);
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = vpn; fill_ppn = ppn;
        fill_rd = r; fill_wr = w; fill_dirty = d; fill_user = u;
        @(posedge clk);
        #1 fill_en = 1'b0;
    endtask

    task automatic flush();
        @(negedge clk);
        flush_all = 1'b1;
        @(posedge clk);
        #1 flush_all = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; flush_all = 1'b0; lk_valid = 1'b0; lk_vaddr = '0;
        lk_store = 1'b0; lk_user = 1'b0; fill_en = 1'b0; fill_vpn = '0;
        fill_ppn = '0; fill_rd = 1'b0; fill_wr = 1'b0; fill_dirty = 1'b0; fill_user = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: empty after reset
        expect_miss("R1", 20'h00010);
        expect_miss("R1", 20'h00000);
        // R3: idle lookup drives nothing
        @(negedge clk);
        lk_valid = 1'b0;
        #1 check("R3", 1'b0, 1'b0, 1'b0, 32'h0);

        // Permission table setup
        fill(20'h00010, 20'h80010, 1, 1, 1, 1);
        fill(20'h00020, 20'h80020, 1, 0, 0, 1);
        fill(20'h00030, 20'h80030, 1, 1, 0, 1);
        fill(20'h00040, 20'h80040, 1, 1, 1, 0);
        fill(20'h00050, 20'h80050, 0, 1, 1, 1);
        for (int i = 0; i < NV; i++) begin
            probe(VECS[i].va, VECS[i].st, VECS[i].us);
            check(req_name(VECS[i].req), VECS[i].hit, VECS[i].miss, VECS[i].flt, VECS[i].pa);
        end

        // R5: refill sets dirty, store then succeeds
        fill(20'h00030, 20'h80030, 1, 1, 1, 1);
        probe(32'h00030444, 1'b1, 1'b1);
        check("R5", 1'b1, 1'b0, 1'b0, 32'h80030444);

        // R11: lookup in the refill's own cycle sees old contents
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = 20'h00070; fill_ppn = 20'hABCDE;
        fill_rd = 1'b1; fill_wr = 1'b0; fill_dirty = 1'b0; fill_user = 1'b1;
        lk_valid = 1'b1; lk_vaddr = 32'h00070010; lk_store = 1'b0; lk_user = 1'b0;
        #1 check("R11", 1'b0, 1'b1, 1'b0, 32'h0);
        @(posedge clk);
        #1 fill_en = 1'b0;
        expect_hit("R11", 20'h00070, 20'hABCDE);

        // R10: flush beats a simultaneous refill
        @(negedge clk);
        flush_all = 1'b1; fill_en = 1'b1; fill_vpn = 20'h00500; fill_ppn = 20'h00501;
        @(posedge clk);
        #1 begin flush_all = 1'b0; fill_en = 1'b0; end
        expect_miss("R10", 20'h00500);
        expect_miss("R10", 20'h00010);
        expect_miss("R10", 20'h00070);

        // R7: overwrite in place
        fill(20'h00300, 20'h11111, 1, 1, 1, 1);
        fill(20'h00300, 20'h22222, 1, 1, 1, 1);
        expect_hit("R7", 20'h00300, 20'h22222);
        flush();

        // R8: fill all slots from empty
        for (int i = 0; i < N; i++) fill(20'h00100 + 20'(i), 20'h00200 + 20'(i), 1, 1, 1, 1);
        expect_hit("R8", 20'h00100, 20'h00200);
        expect_hit("R8", 20'h0013F, 20'h0023F);
        // R9: full array evicts slot 0, then slot 1
        fill(20'h00900, 20'h00990, 1, 1, 1, 1);
        expect_miss("R9", 20'h00100);
        expect_hit("R9", 20'h00101, 20'h00201);
        expect_hit("R9", 20'h00900, 20'h00990);
        fill(20'h00901, 20'h00991, 1, 1, 1, 1);
        expect_miss("R9", 20'h00101);
        expect_hit("R9", 20'h00102, 20'h00202);
        // R7: overwrite does not move the pointer (still at slot 2)
        fill(20'h00120, 20'h00777, 1, 1, 1, 1);
        expect_hit("R7", 20'h00120, 20'h00777);
        fill(20'h00902, 20'h00992, 1, 1, 1, 1);
        expect_miss("R7", 20'h00102);
        expect_hit("R7", 20'h00120, 20'h00777);
        // R8: freed slots refilled lowest first after flush; R10 pointer back at 0
        flush();
        for (int i = 0; i < N; i++) fill(20'h00400 + 20'(i), 20'h00600 + 20'(i), 1, 1, 1, 1);
        fill(20'h00A00, 20'h00AA0, 1, 1, 1, 1);
        expect_miss("R10", 20'h00400);
        expect_hit("R10", 20'h00403, 20'h00603);
        expect_hit("R9", 20'h00A00, 20'h00AA0);
        // R9: wrap of the pointer after 64 evictions
        for (int i = 1; i < N; i++) fill(20'h00B00 + 20'(i), 20'h00C00 + 20'(i), 1, 1, 1, 1);
        expect_hit("R9", 20'h00A00, 20'h00AA0);
        fill(20'h00D00, 20'h00D11, 1, 1, 1, 1);
        expect_miss("R9", 20'h00A00);
        expect_hit("R9", 20'h00B01, 20'h00C01);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule